// File: doc/BRIEF.md
# Eight-line masked-access GPIO port

This block is an eight-pin general purpose I/O port that sits on a simple 32-bit memory-mapped register bus with select, enable, write, address, write data and read data signals. Each transfer has a setup cycle and an access cycle, and no wait states are added. The port holds a direction register, in which a 1 makes a pin an output, and an output data register. It drives the pad output and output-enable lines from these two registers. Pad inputs pass through a two-flop synchroniser before they are read back or passed on.

Pin data is reached through a window of 256 words at the bottom of the map. Address bits [9:2] form a per-pin mask: bit n+2 selects pin n. A write changes only the selected pins. A read returns the level of the selected pins and returns zero for the others. Software can therefore set or clear one pin with a single store, with no read-modify-write. A data bit of a pin that is currently an input does not change. After making a pin an output, software must write its value again.

The seven words above the direction register hold interrupt configuration and status. This port only decodes them. It forwards the register index, the write strobe, the write byte and the read strobe to a separate interrupt detection unit, and returns that unit's read byte. The same unit also receives the synchronised pin levels.

Top module: `gpio_port`

## Requirements
- R1: After reset, pad_oe and pad_out are 0, and a read of the direction word (offset 0x400) returns 0.
- R2: Offset 0x400 holds the direction register. It uses bits [7:0] of the write data and ignores bits [31:8]. A 1 in bit n drives pad_oe[n] high after the access-cycle edge. A read of this offset returns the register value, zero-extended.
- R3: A write to offset A with A[11:10]=0 updates output data bit n only when A[n+2]=1. Every other bit keeps its value on pad_out.
- R4: A data write does not change the bit of a pin whose direction bit is 0. When that pin later becomes an output, pad_out shows the old value until the bit is written again.
- R5: A read of offset A with A[11:10]=0 returns the synchronised pin level in bit n when A[n+2]=1. It returns 0 in every other bit, including bits [31:8].
- R6: A change on pad_in appears on pin_sync and on data reads after the second rising edge, and not after the first.
- R7: A write to offsets 0x404 to 0x41C drives irq_wr high during the access cycle, with irq_sel = A[4:2] (1 to 7) and irq_wdata = write data [7:0]. It changes neither pad_out nor pad_oe.
- R8: A read of offsets 0x404 to 0x41C drives irq_rd high with irq_sel = A[4:2] and returns irq_rdata, zero-extended.
- R9: Offsets 0x420 to 0xFFC read as 0. A write to them changes neither pad_out nor pad_oe and raises no irq_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Port selected |
| penable | input | 1 | Access cycle of a transfer |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access cycle |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pin_sync | output | 8 | Synchronised pin levels for the interrupt unit |
| irq_sel | output | 3 | Interrupt register index (address bits [4:2]) |
| irq_wr | output | 1 | Write strobe to the interrupt unit |
| irq_rd | output | 1 | Read strobe to the interrupt unit |
| irq_wdata | output | 8 | Write byte to the interrupt unit |
| irq_rdata | input | 8 | Read byte from the interrupt unit |

## Verification
The hardest case to reach is a data bit that was written while its pin was an input. Its effect shows only after a later change of direction. The stimulus writes all ones through the full mask while every pin is an input. It then turns the low nibble into outputs and checks that pad_out stays 0, and finally makes all pins outputs and checks that earlier single-pin values stay in place. Synchroniser latency is checked by changing pad_in just after an edge and sampling pin_sync once after one edge and again after two.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_DATA = 2'd1,
        RGN_DIR  = 2'd2,
        RGN_IRQ  = 2'd3
    } gpio_rgn_e;

    localparam int unsigned CTRL_BASE = 32'h400;
    localparam int unsigned IDX_W     = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;

    // R6: output is the first stage delayed by exactly one edge
    p_two_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.s2 == $past(st_q.s1)));
endmodule

// File: rtl/gpio_decode.sv
module gpio_decode
    import gpio_pkg::*;
#(
    parameter int unsigned NPIN = 8,
    parameter int unsigned AW   = 12
) (
    input  logic [AW-1:0]    addr,
    output gpio_rgn_e        rgn,
    output logic [NPIN-1:0]  mask,
    output logic [IDX_W-1:0] idx
);
    localparam int unsigned WIN_TOP = NPIN + 2;
    localparam logic [AW-1:0] CTRL_A = AW'(CTRL_BASE);

    logic data_hit, ctrl_hit;

    always_comb begin
        data_hit = (addr[AW-1:WIN_TOP] == '0);
        ctrl_hit = (addr[AW-1:IDX_W+2] == CTRL_A[AW-1:IDX_W+2]);
        mask     = addr[WIN_TOP-1:2];
        idx      = addr[IDX_W+1:2];
        if (data_hit)            rgn = RGN_DATA;
        else if (!ctrl_hit)      rgn = RGN_NONE;
        else if (idx == '0)      rgn = RGN_DIR;
        else                     rgn = RGN_IRQ;
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
    parameter int unsigned NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_dir,
    input  logic            wr_data,
    input  logic [NPIN-1:0] mask,
    input  logic [NPIN-1:0] wdata,
    output logic [NPIN-1:0] dir_q,
    output logic [NPIN-1:0] data_q
);
    typedef struct packed {
        logic [NPIN-1:0] dir;
        logic [NPIN-1:0] data;
    } regs_t;

    regs_t r_d, r_q;
    logic [NPIN-1:0] upd;

    always_comb begin
        r_d = r_q;
        upd = mask & r_q.dir;
        if (wr_dir)  r_d.dir  = wdata;
        if (wr_data) r_d.data = (r_q.data & ~upd) | (wdata & upd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dir_q  = r_q.dir;
    assign data_q = r_q.data;

    // R2: direction changes only on a direction write
    p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(dir_q));

    // R4: data bits of input pins never change
    p_input_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((data_q ^ $past(data_q)) & ~$past(dir_q)) == '0));

    // R3: data bits outside the address mask never change
    p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> (((data_q ^ $past(data_q)) & ~$past(mask)) == '0));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int unsigned NPIN = 8,
    parameter int unsigned AW   = 12,
    parameter int unsigned DW   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psel,
    input  logic             penable,
    input  logic             pwrite,
    input  logic [AW-1:0]    paddr,
    input  logic [DW-1:0]    pwdata,
    output logic [DW-1:0]    prdata,
    input  logic [NPIN-1:0]  pad_in,
    output logic [NPIN-1:0]  pad_out,
    output logic [NPIN-1:0]  pad_oe,
    output logic [NPIN-1:0]  pin_sync,
    output logic [IDX_W-1:0] irq_sel,
    output logic             irq_wr,
    output logic             irq_rd,
    output logic [NPIN-1:0]  irq_wdata,
    input  logic [NPIN-1:0]  irq_rdata
);
    gpio_rgn_e       rgn;
    logic [NPIN-1:0] mask;
    logic [IDX_W-1:0] idx;
    logic            access, wr_acc, rd_acc;
    logic [NPIN-1:0] dir_q, data_q, sync_lvl;

    gpio_decode #(.NPIN(NPIN), .AW(AW)) u_dec (
        .addr (paddr),
        .rgn  (rgn),
        .mask (mask),
        .idx  (idx)
    );

    gpio_sync #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (sync_lvl)
    );

    always_comb begin
        access = psel & penable;
        wr_acc = access & pwrite;
        rd_acc = access & ~pwrite;
    end

    gpio_regs #(.NPIN(NPIN)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_dir  (wr_acc && (rgn == RGN_DIR)),
        .wr_data (wr_acc && (rgn == RGN_DATA)),
        .mask    (mask),
        .wdata   (pwdata[NPIN-1:0]),
        .dir_q   (dir_q),
        .data_q  (data_q)
    );

    always_comb begin
        prdata = '0;
        if (rd_acc) begin
            unique case (rgn)
                RGN_DATA: prdata[NPIN-1:0] = sync_lvl & mask;
                RGN_DIR:  prdata[NPIN-1:0] = dir_q;
                RGN_IRQ:  prdata[NPIN-1:0] = irq_rdata;
                default:  prdata = '0;
            endcase
        end
    end

    assign pad_out   = data_q;
    assign pad_oe    = dir_q;
    assign pin_sync  = sync_lvl;
    assign irq_sel   = idx;
    assign irq_wdata = pwdata[NPIN-1:0];
    assign irq_wr    = wr_acc && (rgn == RGN_IRQ);
    assign irq_rd    = rd_acc && (rgn == RGN_IRQ);

    // R7: interrupt strobe only in a write access cycle to a nonzero index
    p_irq_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wr |-> (psel && penable && pwrite && (irq_sel != '0)));

    // R7: an interrupt register write leaves pads untouched
    p_irq_no_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wr |=> ($stable(pad_out) && $stable(pad_oe)));

    // R5: unselected data bits read as zero
    p_read_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && (paddr[AW-1:NPIN+2] == '0)) |-> ((prdata[NPIN-1:0] & ~paddr[NPIN+1:2]) == '0));

    // R9: writes to unmapped offsets leave pads untouched
    p_unmapped_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && (rgn == RGN_NONE)) |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out, pad_oe, pin_sync, irq_wdata, irq_rdata;
    logic [2:0]  irq_sel;
    logic        irq_wr, irq_rd;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    logic       seen_wr, seen_rd;
    logic [2:0] seen_sel;
    logic [7:0] seen_wdata;

    always #2 clk = ~clk;

    assign irq_rdata = {irq_sel, 5'h15};

    gpio_port dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pin_sync(pin_sync), .irq_sel(irq_sel),
        .irq_wr(irq_wr), .irq_rd(irq_rd), .irq_wdata(irq_wdata), .irq_rdata(irq_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected read data in the access cycle
    always @(negedge clk) begin
        if (psel && penable && !pwrite) begin
            checks++;
            if (sb.size() == 0) begin
                failures++;
                $display("FAIL scoreboard actual=%h expected=none", prdata);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (prdata !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", it.req, prdata, it.exp);
                end
            end
        end
    end

    task automatic bus_xfer(input logic wr, input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(posedge clk); #1;
        penable = 1'b1;
        @(negedge clk);
        seen_wr = irq_wr; seen_rd = irq_rd; seen_sel = irq_sel; seen_wdata = irq_wdata;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_xfer(1'b1, a, d);
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string req);
        item_t it;
        it.exp = exp; it.req = req;
        sb.push_back(it);
        bus_xfer(1'b0, a, 32'h0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pad_oe", pad_oe, 0);
        chk("R1 pad_out", pad_out, 0);
        bus_read(12'h400, 32'h0, "R1 dir read");
        bus_read(12'h3FC, 32'h0, "R5 data read low pads");

        // R4: write while all inputs has no effect
        bus_write(12'h3FC, 32'hFF);
        bus_write(12'h400, 32'h0F);
        chk("R2 pad_oe", pad_oe, 8'h0F);
        chk("R4 stale write", pad_out, 8'h00);
        bus_read(12'h400, 32'h0F, "R2 dir read");

        // R3: masked writes
        bus_write(12'h3FC, 32'hA5);
        chk("R3 full mask", pad_out, 8'h05);
        bus_write(12'h008, 32'hFF);
        chk("R3 single pin1", pad_out, 8'h07);
        bus_write(12'h010, 32'h00);
        chk("R3 single pin2 clear", pad_out, 8'h03);
        bus_write(12'h400, 32'hFF);
        chk("R4 after dir change", pad_out, 8'h03);
        bus_write(12'h0C0, 32'hFF);
        chk("R3 pins 4,5", pad_out, 8'h33);
        bus_write(12'h400, 32'hFFFFFF3C);
        bus_read(12'h400, 32'h3C, "R2 upper bits ignored");
        chk("R2 pad_oe 3C", pad_oe, 8'h3C);

        // R5: masked reads
        pad_in = 8'h5A;
        repeat (3) @(posedge clk);
        bus_read(12'h3FC, 32'h5A, "R5 full read");
        bus_read(12'h0F0, 32'h18, "R5 partial read");
        bus_read(12'h000, 32'h00, "R5 empty mask");

        // R6: two-flop latency
        @(posedge clk); #1 pad_in = 8'hC3;
        @(negedge clk);
        @(negedge clk);
        chk("R6 after one edge", pin_sync, 8'h5A);
        @(negedge clk);
        chk("R6 after two edges", pin_sync, 8'hC3);

        // R7 / R8: interrupt register forwarding
        bus_write(12'h410, 32'h1234569C);
        chk("R7 irq_wr", seen_wr, 1);
        chk("R7 irq_sel", seen_sel, 3'd4);
        chk("R7 irq_wdata", seen_wdata, 8'h9C);
        chk("R7 pad_out kept", pad_out, 8'h33);
        chk("R7 pad_oe kept", pad_oe, 8'h3C);
        bus_read(12'h418, 32'hD5, "R8 read sel6");
        chk("R8 irq_rd", seen_rd, 1);
        bus_read(12'h404, 32'h35, "R8 read sel1");

        // R9: unmapped offsets
        bus_write(12'h420, 32'hFF);
        chk("R9 no irq_wr", seen_wr, 0);
        bus_write(12'h800, 32'h00);
        chk("R9 pad_out kept", pad_out, 8'h33);
        chk("R9 pad_oe kept", pad_oe, 8'h3C);
        bus_read(12'h420, 32'h0, "R9 read 0x420");
        bus_read(12'hFFC, 32'h0, "R9 read 0xFFC");

        repeat (2) @(posedge clk);
        chk("R9 scoreboard drained", sb.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule